// File: doc/BRIEF.md
# TCP Response Timeout and Retry Controller

This block times the wait for a peer's response in a single-session hardware TCP engine and decides what the engine does when that response does not arrive in time. The stack reports its current waiting phase and pulses a start strobe when it begins to wait. A down-counting timer is then loaded from a 32-bit timeout value, counted in core clock ticks. When the stack reports that the awaited response has arrived, the wait is cancelled. If the phase changes, the wait is abandoned.

When the timer runs out, a recovery policy picks one command for the packet builder. The choice depends on the phase and on how many resends that phase has already made. Address resolution, data transmission and receive-loss recovery resend without limit. Connection open and passive close resend a bounded number of times and then fall back to FIN or RST. Active close falls back to RST at the first timeout. Each timeout raises a one-cycle interrupt together with the command strobe and sets a sticky cause bit. After a resend the timer reloads and the wait goes on. After a fallback command the wait ends.

The FSM has three states. ST_IDLE means no wait. ST_WAIT means the timer is running. ST_FIRE lasts one cycle and presents the command. Its transitions are:
- start (ST_IDLE to ST_WAIT, and ST_WAIT or ST_FIRE to ST_WAIT on a restart)
- cancel (ST_WAIT or ST_FIRE to ST_IDLE on response or phase change)
- expire (ST_WAIT to ST_FIRE)
- silent reload (ST_WAIT to ST_WAIT)
- resend reload (ST_FIRE to ST_WAIT)
- fallback end (ST_FIRE to ST_IDLE)

Top module: `tcp_retry_ctrl`

## Requirements
- R1: After reset, wait_active, act_valid and tmo_irq are 0, tmo_status is 0 and retry_count is 0.
- R2: A wait_start with phase_i not 0, sampled at clock edge k with timeout value T, makes act_valid and tmo_irq high for the cycle after edge k+T. A T of 0 behaves like 1.
- R3: A resend reloads the timer, so the next command in the same wait follows T+1 cycles after the previous one.
- R4: tmo_irq is high for exactly one cycle per timeout and coincides with act_valid.
- R5: Phase 1 (address resolution) always issues command 0 (resend ARP), with no limit, and sets status bit 0.
- R6: Phase 2 (active open) issues command 1 (resend SYN) for the first 16 timeouts. It then issues command 4 (send FIN) and the wait ends. Status bit 1 is set.
- R7: Phase 3 (passive open) issues command 2 (resend SYN/ACK) 16 times, then command 4 (send FIN), and the wait ends. Status bit 2 is set.
- R8: Phase 4 (active close) issues command 5 (send RST) at the first timeout and the wait ends. Status bit 3 is set.
- R9: Phase 5 (passive close) issues command 3 (resend FIN/ACK) 16 times, then command 5 (send RST), and the wait ends. Status bit 4 is set.
- R10: Phase 6 (data transmit) issues command 6 (retransmit data) and sets status bit 5. Phase 7 (receive loss) issues command 7 (duplicate ACK) and sets status bit 6. Neither phase has a limit.
- R11: In phase 6, when win_small and data_left are both 1, a timeout issues command 6 and sets status bit 7 if swin_en is 1. If swin_en is 0, the timeout has no effect: no command, no interrupt, no status bit, and the wait continues.
- R12: resp_ok ends a wait without any command and clears retry_count.
- R13: A change of phase_i during a wait ends it and clears retry_count. Status bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| timeout_val | input | 32 | Timer load value in clock ticks |
| phase_i | input | 3 | Current waiting phase, 0 means none |
| wait_start | input | 1 | Stack begins waiting for a response |
| resp_ok | input | 1 | Expected response arrived |
| win_small | input | 1 | Peer window is smaller than the packet size |
| data_left | input | 1 | Send command still has data to transmit |
| swin_en | input | 1 | Enable retransmit on a window-stalled send |
| act_valid | output | 1 | Recovery command strobe |
| act_cmd | output | 3 | Recovery command code |
| tmo_irq | output | 1 | Timeout interrupt pulse |
| tmo_status | output | 8 | Sticky timeout cause bits |
| retry_count | output | 5 | Resends made in the current phase |
| wait_active | output | 1 | Timer is running |

## Verification
Each phase code is held through a run of timeouts. This shows whether the retry limit applies to that phase, and whether the switch to the fallback command comes exactly after the sixteenth resend. A zero timeout and the spacing between consecutive commands separate the first expiry from the reload delay. A stalled send is run with the option off and then on, which shows whether the stall suppresses the command or turns it into a small-window retransmit. An early response and a phase change are tried against the running timer, and each is checked for ending the wait silently and clearing the count.

// File: rtl/tcp_retry_pkg.sv
package tcp_retry_pkg;

    typedef enum logic [2:0] {
        PH_NONE   = 3'd0,
        PH_ARP    = 3'd1,
        PH_AOPEN  = 3'd2,
        PH_POPEN  = 3'd3,
        PH_ACLOSE = 3'd4,
        PH_PCLOSE = 3'd5,
        PH_DATA   = 3'd6,
        PH_RXLOSS = 3'd7
    } phase_e;

    typedef enum logic [2:0] {
        ACT_ARP    = 3'd0,
        ACT_SYN    = 3'd1,
        ACT_SYNACK = 3'd2,
        ACT_FINACK = 3'd3,
        ACT_FIN    = 3'd4,
        ACT_RST    = 3'd5,
        ACT_DATA   = 3'd6,
        ACT_DUPACK = 3'd7
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } st_e;

    localparam logic [2:0] CAUSE_ARP    = 3'd0;
    localparam logic [2:0] CAUSE_AOPEN  = 3'd1;
    localparam logic [2:0] CAUSE_POPEN  = 3'd2;
    localparam logic [2:0] CAUSE_ACLOSE = 3'd3;
    localparam logic [2:0] CAUSE_PCLOSE = 3'd4;
    localparam logic [2:0] CAUSE_DATA   = 3'd5;
    localparam logic [2:0] CAUSE_RXLOSS = 3'd6;
    localparam logic [2:0] CAUSE_SWIN   = 3'd7;

endpackage

// File: rtl/tcp_retry_timer.sv
module tcp_retry_timer #(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [TMO_W-1:0] load_val,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q <= TMO_W'(1));
endmodule

// File: rtl/tcp_retry_policy.sv
module tcp_retry_policy
    import tcp_retry_pkg::*;
#(
    parameter int RETRY_MAX = 16,
    parameter int CNT_W     = $clog2(RETRY_MAX + 1)
) (
    input  logic [2:0]       phase,
    input  logic [CNT_W-1:0] retry_cnt,
    input  logic             paused,
    input  logic             swin_en,
    output logic             fire,
    output logic [2:0]       cmd,
    output logic [2:0]       cause,
    output logic             inc,
    output logic             term
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(RETRY_MAX);
    logic room;

    assign room = (retry_cnt < LIM);

    always_comb begin
        fire  = 1'b1;
        cmd   = ACT_ARP;
        cause = CAUSE_ARP;
        inc   = 1'b0;
        term  = 1'b0;
        unique case (phase_e'(phase))
            PH_ARP: begin
                cmd = ACT_ARP;  cause = CAUSE_ARP;
            end
            PH_AOPEN: begin
                cause = CAUSE_AOPEN;
                cmd   = room ? ACT_SYN : ACT_FIN;
                inc   = room;
                term  = !room;
            end
            PH_POPEN: begin
                cause = CAUSE_POPEN;
                cmd   = room ? ACT_SYNACK : ACT_FIN;
                inc   = room;
                term  = !room;
            end
            PH_ACLOSE: begin
                cmd = ACT_RST;  cause = CAUSE_ACLOSE;  term = 1'b1;
            end
            PH_PCLOSE: begin
                cause = CAUSE_PCLOSE;
                cmd   = room ? ACT_FINACK : ACT_RST;
                inc   = room;
                term  = !room;
            end
            PH_DATA: begin
                cmd   = ACT_DATA;
                cause = paused ? CAUSE_SWIN : CAUSE_DATA;
                fire  = !paused || swin_en;
            end
            PH_RXLOSS: begin
                cmd = ACT_DUPACK;  cause = CAUSE_RXLOSS;
            end
            default: fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcp_retry_ctrl.sv
module tcp_retry_ctrl
    import tcp_retry_pkg::*;
#(
    parameter int TMO_W     = 32,
    parameter int RETRY_MAX = 16,
    parameter int CNT_W     = $clog2(RETRY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] timeout_val,
    input  logic [2:0]       phase_i,
    input  logic             wait_start,
    input  logic             resp_ok,
    input  logic             win_small,
    input  logic             data_left,
    input  logic             swin_en,
    output logic             act_valid,
    output logic [2:0]       act_cmd,
    output logic             tmo_irq,
    output logic [7:0]       tmo_status,
    output logic [CNT_W-1:0] retry_count,
    output logic             wait_active
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(RETRY_MAX);

    st_e              st_q, st_d;
    logic [2:0]       phase_q, cmd_q;
    logic             term_q;
    logic [7:0]       status_q;
    logic [CNT_W-1:0] retry_q;
    logic             start_ok, ph_chg, expire, t_load, latch_ph, take;
    logic             pol_fire, pol_inc, pol_term;
    logic [2:0]       pol_cmd, pol_cause;

    assign start_ok = wait_start && (phase_i != PH_NONE);
    assign ph_chg   = (phase_i != phase_q);

    tcp_retry_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .run      (st_q == ST_WAIT),
        .load_val (timeout_val),
        .expire   (expire)
    );

    tcp_retry_policy #(.RETRY_MAX(RETRY_MAX), .CNT_W(CNT_W)) u_policy (
        .phase     (phase_q),
        .retry_cnt (retry_q),
        .paused    (win_small && data_left),
        .swin_en   (swin_en),
        .fire      (pol_fire),
        .cmd       (pol_cmd),
        .cause     (pol_cause),
        .inc       (pol_inc),
        .term      (pol_term)
    );

    always_comb begin
        st_d     = st_q;
        t_load   = 1'b0;
        latch_ph = 1'b0;
        take     = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ok) begin
                    st_d = ST_WAIT; t_load = 1'b1; latch_ph = 1'b1;
                end
            end
            ST_WAIT: begin
                if (resp_ok) begin
                    st_d = ST_IDLE;
                end else if (start_ok) begin
                    t_load = 1'b1; latch_ph = 1'b1;
                end else if (ph_chg) begin
                    st_d = ST_IDLE;
                end else if (expire) begin
                    if (pol_fire) begin
                        st_d = ST_FIRE; take = 1'b1;
                    end else begin
                        t_load = 1'b1;
                    end
                end
            end
            ST_FIRE: begin
                if (resp_ok) begin
                    st_d = ST_IDLE;
                end else if (start_ok) begin
                    st_d = ST_WAIT; t_load = 1'b1; latch_ph = 1'b1;
                end else if (ph_chg || term_q) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d = ST_WAIT; t_load = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_NONE;
            cmd_q    <= ACT_ARP;
            term_q   <= 1'b0;
            status_q <= '0;
            retry_q  <= '0;
        end else begin
            if (latch_ph) phase_q <= phase_i;
            if (take) begin
                cmd_q    <= pol_cmd;
                term_q   <= pol_term;
                status_q <= status_q | (8'd1 << pol_cause);
            end
            if (resp_ok || ph_chg) begin
                retry_q <= '0;
            end else if (take && pol_inc) begin
                retry_q <= retry_q + 1'b1;
            end
        end
    end

    assign act_valid   = (st_q == ST_FIRE);
    assign tmo_irq     = (st_q == ST_FIRE);
    assign act_cmd     = cmd_q;
    assign tmo_status  = status_q;
    assign retry_count = retry_q;
    assign wait_active = (st_q == ST_WAIT);

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |=> !tmo_irq); // R4
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        retry_count <= LIM); // R6
    AST_ARP_ENDLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && phase_q == PH_ARP) |-> act_cmd == ACT_ARP); // R5
    AST_FIN_AFTER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_cmd == ACT_FIN) |-> retry_count == LIM); // R7
    AST_ACLOSE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && phase_q == PH_ACLOSE) |-> act_cmd == ACT_RST); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tmo_status & $past(tmo_status)) == $past(tmo_status))); // R13
    AST_RESP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_ok && st_q == ST_WAIT) |=> (!act_valid && retry_count == '0)); // R12
endmodule

// File: tb/tcp_retry_ctrl_bench.sv
module tcp_retry_ctrl_bench;
    localparam int T = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timeout_val = 32'(T);
    logic [2:0]  phase_i = 3'd0;
    logic        wait_start = 1'b0, resp_ok = 1'b0;
    logic        win_small = 1'b0, data_left = 1'b0, swin_en = 1'b0;
    logic        act_valid, tmo_irq, wait_active;
    logic [2:0]  act_cmd;
    logic [7:0]  tmo_status;
    logic [4:0]  retry_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tcp_retry_ctrl u_tcp_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .timeout_val(timeout_val), .phase_i(phase_i),
        .wait_start(wait_start), .resp_ok(resp_ok), .win_small(win_small),
        .data_left(data_left), .swin_en(swin_en), .act_valid(act_valid),
        .act_cmd(act_cmd), .tmo_irq(tmo_irq), .tmo_status(tmo_status),
        .retry_count(retry_count), .wait_active(wait_active)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic start_wait(input logic [2:0] ph);
        @(negedge clk);
        phase_i = ph; wait_start = 1'b1;
        @(negedge clk);
        wait_start = 1'b0;
    endtask

    task automatic stop_wait();
        resp_ok = 1'b1;
        @(negedge clk);
        resp_ok = 1'b0;
        phase_i = 3'd0;
        @(negedge clk);
    endtask

    // exactly d negedges until the command; silent before it
    task automatic expect_fire(input int d, input logic [2:0] cmd, input string req);
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            if (i < d) chk(!act_valid, req, 32'(act_valid), 0);
        end
        chk(act_valid && tmo_irq, req, 32'({act_valid, tmo_irq}), 3);
        chk(act_cmd == cmd, req, 32'(act_cmd), 32'(cmd));
    endtask

    task automatic t_reset();
        chk(!wait_active && !act_valid && !tmo_irq, "R1", 32'({wait_active, act_valid, tmo_irq}), 0);
        chk(tmo_status == 0 && retry_count == 0, "R1", 32'({tmo_status, retry_count}), 0);
    endtask

    task automatic t_arp();
        start_wait(3'd1);
        expect_fire(T, 3'd0, "R2");
        for (int n = 0; n < 20; n++) expect_fire(T + 1, 3'd0, "R5 R3");
        @(negedge clk);
        chk(!tmo_irq && !act_valid, "R4", 32'(tmo_irq), 0);
        chk(tmo_status[0], "R5", 32'(tmo_status), 1);
        stop_wait();
    endtask

    task automatic t_bounded(input logic [2:0] ph, input logic [2:0] rs,
                             input logic [2:0] fb, input int bitn, input string req);
        start_wait(ph);
        expect_fire(T, rs, req);
        for (int n = 1; n < 16; n++) expect_fire(T + 1, rs, req);
        expect_fire(T + 1, fb, req);
        chk(retry_count == 16, req, 32'(retry_count), 16);
        @(negedge clk);
        chk(!wait_active && !act_valid, req, 32'({wait_active, act_valid}), 0);
        chk(tmo_status[bitn], req, 32'(tmo_status), 32'(1 << bitn));
        phase_i = 3'd0;
        @(negedge clk);
    endtask

    task automatic t_aclose();
        start_wait(3'd4);
        expect_fire(T, 3'd5, "R8");
        @(negedge clk);
        chk(!wait_active, "R8", 32'(wait_active), 0);
        chk(tmo_status[3], "R8", 32'(tmo_status), 8);
        phase_i = 3'd0;
        @(negedge clk);
    endtask

    task automatic t_data_rx();
        start_wait(3'd6);
        expect_fire(T, 3'd6, "R10");
        expect_fire(T + 1, 3'd6, "R10");
        chk(tmo_status[5] && !tmo_status[7], "R10", 32'(tmo_status), 32'h20);
        stop_wait();
        start_wait(3'd7);
        expect_fire(T, 3'd7, "R10");
        expect_fire(T + 1, 3'd7, "R10");
        chk(tmo_status[6], "R10", 32'(tmo_status), 32'h40);
        stop_wait();
    endtask

    task automatic t_swin();
        bit seen;
        win_small = 1'b1; data_left = 1'b1; swin_en = 1'b0;
        start_wait(3'd6);
        seen = 1'b0;
        for (int i = 0; i < 4 * T; i++) begin
            @(negedge clk);
            if (act_valid || tmo_irq) seen = 1'b1;
        end
        chk(!seen, "R11", 32'(seen), 0);
        chk(wait_active && !tmo_status[7], "R11", 32'({wait_active, tmo_status[7]}), 2);
        swin_en = 1'b1;
        for (int i = 0; i < 2 * T + 2 && !act_valid; i++) @(negedge clk);
        chk(act_valid && act_cmd == 3'd6, "R11", 32'({act_valid, act_cmd}), 32'he);
        chk(tmo_status[7], "R11", 32'(tmo_status), 32'h80);
        win_small = 1'b0; data_left = 1'b0; swin_en = 1'b0;
        stop_wait();
    endtask

    task automatic t_resp();
        bit seen;
        start_wait(3'd2);
        expect_fire(T, 3'd1, "R6");
        chk(retry_count == 1, "R12", 32'(retry_count), 1);
        @(negedge clk);
        resp_ok = 1'b1;
        @(negedge clk);
        resp_ok = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (act_valid) seen = 1'b1;
        end
        chk(!seen && !wait_active, "R12", 32'({seen, wait_active}), 0);
        chk(retry_count == 0, "R12", 32'(retry_count), 0);
        phase_i = 3'd0;
        @(negedge clk);
    endtask

    task automatic t_phase_chg();
        start_wait(3'd5);
        expect_fire(T, 3'd3, "R9");
        expect_fire(T + 1, 3'd3, "R9");
        chk(retry_count == 2, "R13", 32'(retry_count), 2);
        @(negedge clk);
        phase_i = 3'd0;
        @(negedge clk);
        chk(!wait_active && retry_count == 0, "R13", 32'({wait_active, retry_count}), 0);
        chk(tmo_status != 0, "R13", 32'(tmo_status), 32'hff);
    endtask

    task automatic t_zero();
        timeout_val = 32'd0;
        start_wait(3'd1);
        expect_fire(1, 3'd0, "R2");
        stop_wait();
        timeout_val = 32'(T);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arp();
        t_bounded(3'd2, 3'd1, 3'd4, 1, "R6");
        t_bounded(3'd3, 3'd2, 3'd4, 2, "R7");
        t_bounded(3'd5, 3'd3, 3'd5, 4, "R9");
        t_aclose();
        t_data_rx();
        t_swin();
        t_resp();
        t_phase_chg();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule